// File: doc/BRIEF.md
# Set-Associative Branch Outcome Predictor with Event Counters

This block learns how conditional branches behave. Each resolved branch is presented once, as its full address and its actual direction. The block locates the set that the address maps to and searches that set's ways for the address. On a hit, it scores the stored prediction against the outcome and then trains the saturating counter. On a miss, it claims a way for the address and seeds that way's counter just beside the midpoint, on the side of the first outcome. A small usage counter per way ages on every access to its set and steers replacement.

Four free-running event counters record the outcome of every accepted update: lookup hits, lookup misses, correct predictions and wrong predictions. A read-only output gives the storage size implied by the parameters. The block has no effect on fetch. It is a measurement and training structure that other logic or a monitor reads through the counters. Each update takes one clock. A synchronous reset empties the table and the counters, so every tag reads as address zero.

Top module: `bpb_top`

## Requirements
- R1: The set used by an update is the complete update address modulo NUM_SETS. Addresses in different sets never displace one another.
- R2: A way hits only when its stored tag equals the full update address. When several ways match, the highest-numbered one is used. After reset every tag is zero, so address 0 hits.
- R3: On a hit, the predicted direction is the way's counter divided by PRED_STATES/2 (1 = taken). If it equals the outcome, good_cnt increments; otherwise bad_cnt increments. A miss touches neither.
- R4: On a hit, a taken outcome raises the counter unless it is at PRED_STATES-1. A not-taken outcome lowers it unless it is 0.
- R5: On a miss, the chosen way receives the update address as its tag and a counter of PRED_STATES/2-1 plus the outcome bit (1 = taken).
- R6: On every accepted update, each way of the addressed set with a nonzero usage counter is lowered by one. The accessed or allocated way is then set to USE_STATES-1.
- R7: The way replaced on a miss is the highest-numbered way whose usage counter is below USE_STATES-1, or way 0 if no way qualifies.
- R8: While en is low, an update changes neither the table nor any event counter.
- R9: While upd_valid is low, nothing changes in the table or the counters.
- R10: A synchronous reset zeroes all tags, prediction counters, usage counters and event counters. It takes priority over an update in the same cycle.
- R11: Every accepted update increments exactly one of hit_cnt and miss_cnt, one clock after it is presented.
- R12: store_bytes equals NUM_SETS × NUM_WAYS × (PRED_STATES + USE_STATES) / 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global enable; low freezes all state |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| hit_cnt | output | STAT_W | Number of lookup hits |
| miss_cnt | output | STAT_W | Number of lookup misses |
| good_cnt | output | STAT_W | Number of correct predictions |
| bad_cnt | output | STAT_W | Number of wrong predictions |
| store_bytes | output | 32 | Table storage size derived from parameters |

## Verification
Two pairs of functions share a cycle. Aging of the other ways and refreshing of the accessed way both happen in the same clock, and the choice of the next victim shows whether the refresh took effect over the decrement. The bench drives alternating accesses to one set and then predicts each later hit or eviction from that ordering. In the second pair, an update with reset raised in the same cycle must leave every counter at zero, and a later access to address 0 must hit with a not-taken prediction.

// File: rtl/bpb_pkg.sv
package bpb_pkg;
    // Width of an index able to hold values 0 .. n-1, never below one bit.
    function automatic int bits_for(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/bpb_lookup.sv
module bpb_lookup #(
    parameter int ADDR_W     = 32,
    parameter int NUM_WAYS   = 1,
    parameter int USE_STATES = 2,
    localparam int WAY_W     = bpb_pkg::bits_for(NUM_WAYS),
    localparam int UW        = bpb_pkg::bits_for(USE_STATES)
) (
    input  logic [NUM_WAYS-1:0][ADDR_W-1:0] tags_i,
    input  logic [NUM_WAYS-1:0][UW-1:0]     use_i,
    input  logic [ADDR_W-1:0]               addr_i,
    output logic                            hit_o,
    output logic [WAY_W-1:0]                hit_way_o,
    output logic [WAY_W-1:0]                victim_o
);
    localparam logic [UW-1:0] UMAX = UW'(USE_STATES - 1);

    logic [NUM_WAYS-1:0] match;
    logic [NUM_WAYS-1:0] aged;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign match[w] = (tags_i[w] == addr_i);
        assign aged[w]  = (use_i[w] < UMAX);
    end

    // Later ways overwrite earlier choices: last match and last aged way win.
    always_comb begin
        hit_o     = 1'b0;
        hit_way_o = '0;
        victim_o  = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (match[w]) begin
                hit_o     = 1'b1;
                hit_way_o = WAY_W'(w);
            end
            if (aged[w]) begin
                victim_o = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/bpb_pred_step.sv
module bpb_pred_step #(
    parameter int PRED_STATES = 2,
    localparam int PW         = bpb_pkg::bits_for(PRED_STATES)
) (
    input  logic          hit_i,
    input  logic          taken_i,
    input  logic [PW-1:0] cur_i,
    output logic [PW-1:0] nxt_o,
    output logic          correct_o
);
    localparam int            HALF = PRED_STATES / 2;
    localparam logic [PW-1:0] PMAX = PW'(PRED_STATES - 1);
    localparam logic [PW-1:0] SEED = PW'(HALF - 1);

    logic dir;
    assign dir       = ((32'(cur_i) / HALF) != 0);
    assign correct_o = (dir == taken_i);

    always_comb begin
        if (!hit_i) begin
            nxt_o = SEED + PW'(taken_i);
        end else if (taken_i) begin
            nxt_o = (cur_i == PMAX) ? cur_i : cur_i + 1'b1;
        end else begin
            nxt_o = (cur_i == '0) ? cur_i : cur_i - 1'b1;
        end
    end
endmodule

// File: rtl/bpb_stats.sv
module bpb_stats #(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_i,
    input  logic              hit_i,
    input  logic              correct_i,
    output logic [STAT_W-1:0] hit_o,
    output logic [STAT_W-1:0] miss_o,
    output logic [STAT_W-1:0] good_o,
    output logic [STAT_W-1:0] bad_o
);
    typedef struct packed {
        logic [STAT_W-1:0] hit;
        logic [STAT_W-1:0] miss;
        logic [STAT_W-1:0] good;
        logic [STAT_W-1:0] bad;
    } stats_t;

    stats_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (act_i) begin
            if (hit_i) begin
                st_d.hit = st_q.hit + 1'b1;
                if (correct_i) st_d.good = st_q.good + 1'b1;
                else           st_d.bad  = st_q.bad + 1'b1;
            end else begin
                st_d.miss = st_q.miss + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hit_o  = st_q.hit;
    assign miss_o = st_q.miss;
    assign good_o = st_q.good;
    assign bad_o  = st_q.bad;
endmodule

// File: rtl/bpb_top.sv
module bpb_top #(
    parameter int ADDR_W      = 32,
    parameter int NUM_SETS    = 64,
    parameter int NUM_WAYS    = 1,
    parameter int PRED_STATES = 2,
    parameter int USE_STATES  = 2,
    parameter int STAT_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    output logic [STAT_W-1:0] hit_cnt,
    output logic [STAT_W-1:0] miss_cnt,
    output logic [STAT_W-1:0] good_cnt,
    output logic [STAT_W-1:0] bad_cnt,
    output logic [31:0]       store_bytes
);
    localparam int IDX_W = bpb_pkg::bits_for(NUM_SETS);
    localparam int WAY_W = bpb_pkg::bits_for(NUM_WAYS);
    localparam int PW    = bpb_pkg::bits_for(PRED_STATES);
    localparam int UW    = bpb_pkg::bits_for(USE_STATES);
    localparam int BYTES = NUM_SETS * NUM_WAYS * (PRED_STATES + USE_STATES) / 8;
    localparam logic [UW-1:0] UMAX = UW'(USE_STATES - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] tag;
        logic [PW-1:0]     pred;
        logic [UW-1:0]     age;
    } way_t;

    typedef way_t [NUM_WAYS-1:0] set_t;

    set_t [NUM_SETS-1:0] tbl_d, tbl_q;

    logic                           act;
    logic [IDX_W-1:0]               idx;
    set_t                           cur_set;
    logic [NUM_WAYS-1:0][ADDR_W-1:0] cur_tags;
    logic [NUM_WAYS-1:0][UW-1:0]     cur_age;
    logic                           hit;
    logic [WAY_W-1:0]               hit_way;
    logic [WAY_W-1:0]               victim;
    logic [WAY_W-1:0]               sel_way;
    logic [PW-1:0]                  pred_nxt;
    logic                           correct;

    assign act     = en & upd_valid;
    assign idx     = IDX_W'(upd_addr % ADDR_W'(NUM_SETS));
    assign cur_set = tbl_q[idx];
    assign sel_way = hit ? hit_way : victim;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_split
        assign cur_tags[w] = cur_set[w].tag;
        assign cur_age[w]  = cur_set[w].age;
    end

    bpb_lookup #(
        .ADDR_W    (ADDR_W),
        .NUM_WAYS  (NUM_WAYS),
        .USE_STATES(USE_STATES)
    ) u_lookup (
        .tags_i   (cur_tags),
        .use_i    (cur_age),
        .addr_i   (upd_addr),
        .hit_o    (hit),
        .hit_way_o(hit_way),
        .victim_o (victim)
    );

    bpb_pred_step #(
        .PRED_STATES(PRED_STATES)
    ) u_step (
        .hit_i    (hit),
        .taken_i  (upd_taken),
        .cur_i    (cur_set[hit_way].pred),
        .nxt_o    (pred_nxt),
        .correct_o(correct)
    );

    bpb_stats #(
        .STAT_W(STAT_W)
    ) u_stats (
        .clk      (clk),
        .rst      (rst),
        .act_i    (act),
        .hit_i    (hit),
        .correct_i(correct),
        .hit_o    (hit_cnt),
        .miss_o   (miss_cnt),
        .good_o   (good_cnt),
        .bad_o    (bad_cnt)
    );

    // Age the whole set first, then refresh and rewrite the chosen way.
    always_comb begin
        tbl_d = tbl_q;
        if (act) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (tbl_q[idx][w].age != '0) begin
                    tbl_d[idx][w].age = tbl_q[idx][w].age - 1'b1;
                end
            end
            tbl_d[idx][sel_way].tag  = upd_addr;
            tbl_d[idx][sel_way].pred = pred_nxt;
            tbl_d[idx][sel_way].age  = UMAX;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tbl_q <= '0;
        else     tbl_q <= tbl_d;
    end

    assign store_bytes = 32'(BYTES);
endmodule

// File: rtl/bpb_chk.sv
module bpb_chk #(
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              upd_valid,
    input logic [STAT_W-1:0] hit_cnt,
    input logic [STAT_W-1:0] miss_cnt,
    input logic [STAT_W-1:0] good_cnt,
    input logic [STAT_W-1:0] bad_cnt
);
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    assert_lookup_once_R11: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(rst) && $past(en) && $past(upd_valid)) |->
        (STAT_W'(hit_cnt + miss_cnt) == STAT_W'($past(hit_cnt) + $past(miss_cnt) + 1'b1)));

    assert_score_on_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(rst)) |->
        (STAT_W'((good_cnt - $past(good_cnt)) + (bad_cnt - $past(bad_cnt)))
            == STAT_W'(hit_cnt - $past(hit_cnt))));

    assert_frozen_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(rst) && !$past(en)) |->
        ($stable(hit_cnt) && $stable(miss_cnt) && $stable(good_cnt) && $stable(bad_cnt)));

    assert_idle_without_valid_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(rst) && !$past(upd_valid)) |->
        ($stable(hit_cnt) && $stable(miss_cnt) && $stable(good_cnt) && $stable(bad_cnt)));

    assert_cleared_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(rst)) |->
        (hit_cnt == '0 && miss_cnt == '0 && good_cnt == '0 && bad_cnt == '0));
endmodule

bind bpb_top bpb_chk #(
    .STAT_W(STAT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .upd_valid(upd_valid),
    .hit_cnt  (hit_cnt),
    .miss_cnt (miss_cnt),
    .good_cnt (good_cnt),
    .bad_cnt  (bad_cnt)
);

// File: tb/bpb_top_tb.sv
module bpb_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int SW = 16;
    localparam int NV = 18;

    // Bench instance: 4 sets, 2 ways, 4 prediction states, 2 usage states.
    localparam int V_ADDR[NV] = '{0, 4, 4, 4, 4, 4, 4, 8, 8, 4, 12, 8, 12, 4, 5, 5, 5, 5};
    localparam int V_TKN [NV] = '{1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 0};
    localparam int V_HIT [NV] = '{1, 1, 2, 3, 4, 5, 6, 6, 7, 8, 8, 8, 9, 9, 9, 10, 11, 12};
    localparam int V_MISS[NV] = '{0, 1, 1, 1, 1, 1, 1, 2, 2, 2, 3, 4, 4, 5, 6, 6, 6, 6};
    localparam int V_GOOD[NV] = '{0, 0, 1, 1, 1, 2, 3, 3, 4, 5, 5, 5, 6, 6, 6, 7, 8, 8};
    localparam int V_BAD [NV] = '{1, 1, 1, 2, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 4};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b1;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_addr = '0;
    logic          upd_taken = 1'b0;
    logic [SW-1:0] hit_cnt, miss_cnt, good_cnt, bad_cnt;
    logic [31:0]   store_bytes;

    int  n_run  = 0;
    int  n_fail = 0;
    logic done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bpb_top #(
        .ADDR_W     (AW),
        .NUM_SETS   (4),
        .NUM_WAYS   (2),
        .PRED_STATES(4),
        .USE_STATES (2),
        .STAT_W     (SW)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .upd_valid  (upd_valid),
        .upd_addr   (upd_addr),
        .upd_taken  (upd_taken),
        .hit_cnt    (hit_cnt),
        .miss_cnt   (miss_cnt),
        .good_cnt   (good_cnt),
        .bad_cnt    (bad_cnt),
        .store_bytes(store_bytes)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_stats(input string req, input int h, input int m, input int g, input int b);
        check(req, "hit_cnt",  int'(hit_cnt),  h);
        check(req, "miss_cnt", int'(miss_cnt), m);
        check(req, "good_cnt", int'(good_cnt), g);
        check(req, "bad_cnt",  int'(bad_cnt),  b);
    endtask

    // Present one update at a falling edge; results are sampled one cycle later.
    task automatic update(input int addr, input bit tkn, input bit e, input bit v);
        @(negedge clk);
        upd_addr  = AW'(addr);
        upd_taken = tkn;
        en        = e;
        upd_valid = v;
        @(negedge clk);
        upd_valid = 1'b0;
        en        = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state; R12: storage size 4*2*(4+2)/8 = 6
        check_stats("R10", 0, 0, 0, 0);
        check("R12", "store_bytes", int'(store_bytes), 6);

        // R1 R2 R3 R4 R5 R6 R7 R11: table walk over sets 0 and 1
        for (int i = 0; i < NV; i++) begin
            update(V_ADDR[i], V_TKN[i] != 0, 1'b1, 1'b1);
            check_stats($sformatf("R1 R2 R3 R4 R5 R6 R7 R11 step%0d", i),
                        V_HIT[i], V_MISS[i], V_GOOD[i], V_BAD[i]);
        end

        // R8: disabled updates leave counters and the counter of address 5 (now 2) alone
        update(5, 1'b0, 1'b0, 1'b1);
        update(5, 1'b0, 1'b0, 1'b1);
        check_stats("R8 frozen", 12, 6, 8, 4);
        update(5, 1'b1, 1'b1, 1'b1);
        check_stats("R8 state kept", 13, 6, 9, 4);

        // R9: updates without valid are ignored (counter of address 5 stays 3)
        update(5, 1'b0, 1'b1, 1'b0);
        update(5, 1'b0, 1'b1, 1'b0);
        check_stats("R9 idle", 13, 6, 9, 4);
        update(5, 1'b1, 1'b1, 1'b1);
        check_stats("R9 state kept", 14, 6, 10, 4);

        // R10: reset in the same cycle as an update wins
        @(negedge clk);
        rst       = 1'b1;
        upd_valid = 1'b1;
        upd_addr  = AW'(5);
        upd_taken = 1'b1;
        @(negedge clk);
        rst       = 1'b0;
        upd_valid = 1'b0;
        check_stats("R10 reset wins", 0, 0, 0, 0);

        // R2 R10: cleared tags match address 0, cleared counter predicts not taken
        update(0, 1'b0, 1'b1, 1'b1);
        check_stats("R2 R10 after reset", 1, 0, 1, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule